// File: doc/BRIEF.md
# Two-Wire Sensor Target with Alert Response

This block is the bus-facing target of a small register-mapped sensor on an open-drain two-wire bus (I2C/SMBus). The clock and data lines are brought into the system clock domain through a two-flop synchroniser and a short glitch filter. START and STOP conditions are detected on the cleaned lines. The target answers a 7-bit address whose upper five bits are fixed at `10010` and whose two low bits come from a strap input. A write carries one pointer byte, and the pointer selects one of four 16-bit registers that arrive as input ports. A read returns the selected register as a word. The pointer is kept between transactions, so a sensor value can be polled again and again with no pointer write in between.

The block also responds to the SMBus alert-response address. A rising edge on the alert condition input latches the alert output. While that output is high, the target acknowledges address `0001100` with R/W=1. It then sends one byte: its own address followed by a status bit. During that byte it checks for lost arbitration on every bit it sends as 1. If it wins, it clears its alert output. If it loses, it releases the bus and keeps the alert.

The engine is a single state machine with these states:
- `ST_IDLE`: waits for a START.
- `ST_ADDR`: shifts in the address byte.
- `ST_ADDR_ACK`: acknowledges the address.
- `ST_PTR`: shifts in the pointer byte.
- `ST_PTR_ACK`: acknowledges the pointer byte.
- `ST_TX`: sends a register byte.
- `ST_TX_ACK`: samples the controller's acknowledge.
- `ST_ARA_TX`: sends the alert-response byte and checks arbitration.
- `ST_ARA_ACK`: the controller's acknowledge slot after the alert byte.
- `ST_IGNORE`: the bus is released until the next START or STOP.

Transitions:
- A STOP from any state goes to `ST_IDLE`.
- A START from any state goes to `ST_ADDR`.
- `ST_ADDR` goes to `ST_ADDR_ACK` on a match and to `ST_IGNORE` otherwise.
- `ST_ADDR_ACK` goes to `ST_PTR`, `ST_TX` or `ST_ARA_TX`, according to R/W and which address matched.
- `ST_PTR` goes to `ST_PTR_ACK`, and `ST_PTR_ACK` goes to `ST_IGNORE`.
- `ST_TX` goes to `ST_TX_ACK`. `ST_TX_ACK` goes back to `ST_TX` on an ACK when a byte remains, and to `ST_IGNORE` otherwise.
- `ST_ARA_TX` goes to `ST_ARA_ACK` when all eight bits are sent, or to `ST_IGNORE` on lost arbitration.
- `ST_ARA_ACK` goes to `ST_IGNORE`.

Top module: `tws_sensor_target`

## Requirements
- R1: After reset the target releases SDA, `alert_o` is low and the pointer is 0, so a first read returns register 0.
- R2: The target acknowledges (pulls SDA low in the ninth clock) an address byte whose bits 7..3 are `10010`, whose bits 2..1 equal `addr_strap_i[1:0]` and whose bit 0 is R/W. Any other address gets no acknowledge, and SDA stays released until the next START or STOP.
- R3: After its address with R/W=0, the target acknowledges the next byte as a pointer. Bits 1..0 of that byte select register k, which is `reg_data_i[16*k+15:16*k]`. Any further write bytes get no acknowledge.
- R4: After its address with R/W=1, the target sends bits 15..8 of the selected register, then bits 7..0. Each byte is sent MSB first.
- R5: An ACK (SDA low) from the controller after the first data byte makes the target send the second byte. A NACK after either byte ends the read, and SDA stays released after it.
- R6: The pointer keeps its value across STOP and across reads, and changes only through a pointer write.
- R7: A repeated START in mid-transfer restarts address reception and leaves the pointer unchanged.
- R8: `alert_o` rises one clock after a rising edge of `alert_i`. Address `0001100` with R/W=1 is acknowledged only while `alert_o` is high.
- R9: After acknowledging the alert-response address, the target sends the byte {its 7-bit address, `alert_i` level}. When all eight bits have gone out, `alert_o` is cleared.
- R10: If SDA reads low while the target sends a 1 in the alert-response byte, the target releases SDA for the rest of the byte and keeps `alert_o` high.
- R11: A SDA pulse shorter than the filter length while SCL is high is not taken as a START or STOP. A STOP returns the target to idle with SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | High to pull the data line low |
| addr_strap_i | input | 2 | Low two address bits |
| reg_data_i | input | 64 | Four 16-bit registers, register k at bits 16k+15..16k |
| alert_i | input | 1 | Alert condition level |
| alert_o | output | 1 | Latched alert output |

## Verification
A bus change reaches the engine about six clocks late: two synchroniser flops, three filter cycles and one edge register. The target therefore moves SDA about seven clocks after a falling SCL. The bench changes its own SDA ten clocks after each SCL fall, and it samples data twenty clocks into the SCL-high phase, so every bit and acknowledge is read well after it has settled. `alert_o` is due on the first clock edge after `alert_i` rises. It is compared against the reference model every clock. The comparison is paused only inside an alert-response transfer, where the clear time depends on the filter delay; the value is checked again once that transfer has ended.

// File: rtl/tws_pkg.sv
package tws_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_ARA_TX,
        ST_ARA_ACK,
        ST_IGNORE
    } tws_state_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    localparam logic [4:0] DEV_ADDR_HI = 5'b10010;
    localparam logic [6:0] ALERT_RESP_ADDR = 7'b0001100;

endpackage

// File: rtl/tws_line_filter.sv
module tws_line_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic clean_o
);
    localparam int CNT_W = $clog2(FILT_LEN + 1);

    logic             meta_q;
    logic             sync_q;
    logic [CNT_W-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q  <= 1'b1;
            sync_q  <= 1'b1;
            clean_o <= 1'b1;
            run_q   <= '0;
        end else begin
            meta_q <= raw_i;
            sync_q <= meta_q;
            if (sync_q != clean_o) begin
                if (run_q == CNT_W'(FILT_LEN - 1)) begin
                    clean_o <= sync_q;
                    run_q   <= '0;
                end else begin
                    run_q <= run_q + 1'b1;
                end
            end else begin
                run_q <= '0;
            end
        end
    end

    // R11
    filt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clean_o != $past(clean_o)) |-> ($past(sync_q) == clean_o));

endmodule

// File: rtl/tws_bus_events.sv
module tws_bus_events
    import tws_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt_o
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        evt_o.scl_rise = scl_i & ~scl_q;
        evt_o.scl_fall = ~scl_i & scl_q;
        evt_o.start    = scl_i & scl_q & sda_q & ~sda_i;
        evt_o.stop     = scl_i & scl_q & ~sda_q & sda_i;
    end

endmodule

// File: rtl/tws_target_fsm.sv
module tws_target_fsm
    import tws_pkg::*;
#(
    parameter int REG_W = 16,
    parameter int NREG  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_evt_t          evt_i,
    input  logic              sda_s_i,
    input  logic [1:0]        strap_i,
    input  logic [NREG*REG_W-1:0] regs_i,
    input  logic              alert_i,
    output logic              sda_oe_o,
    output logic              alert_o
);
    localparam int BYTE_W = 8;
    localparam int BYTES  = REG_W / BYTE_W;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam int BIDX_W = $clog2(BYTES + 1);
    localparam int PTR_W  = $clog2(NREG);

    tws_state_e        state, next_state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic [BIDX_W-1:0] byte_idx;
    logic [PTR_W-1:0]  ptr;
    logic              rw_q;
    logic              ara_q;
    logic              ctl_ack;
    logic              alert_in_q;

    logic [REG_W-1:0]  sel_word;
    logic              own_hit;
    logic              ara_hit;
    logic              last_bit;
    logic              lost_arb;
    logic [BYTE_W-1:0] next_byte;

    assign sel_word  = regs_i[int'(ptr)*REG_W +: REG_W];
    assign own_hit   = (rx_sh[7:1] == {DEV_ADDR_HI, strap_i});
    assign ara_hit   = (rx_sh[7:1] == ALERT_RESP_ADDR) && rx_sh[0] && alert_o;
    assign last_bit  = (bit_cnt == CNT_W'(BYTE_W - 1));
    assign lost_arb  = evt_i.scl_rise && tx_sh[7] && !sda_s_i;
    assign next_byte = BYTE_W'(sel_word >> (BYTE_W * (BYTES - 2 - int'(byte_idx))));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= next_state;
    end

    // Next-state logic
    always_comb begin
        next_state = state;
        if (evt_i.stop) begin
            next_state = ST_IDLE;
        end else if (evt_i.start) begin
            next_state = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE, ST_IGNORE: next_state = state;
                ST_ADDR:
                    if (evt_i.scl_fall && bit_cnt == CNT_W'(BYTE_W))
                        next_state = (own_hit || ara_hit) ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK:
                    if (evt_i.scl_fall)
                        next_state = ara_q ? ST_ARA_TX : (rw_q ? ST_TX : ST_PTR);
                ST_PTR:
                    if (evt_i.scl_fall && bit_cnt == CNT_W'(BYTE_W))
                        next_state = ST_PTR_ACK;
                ST_PTR_ACK:
                    if (evt_i.scl_fall) next_state = ST_IGNORE;
                ST_TX:
                    if (evt_i.scl_fall && last_bit) next_state = ST_TX_ACK;
                ST_TX_ACK:
                    if (evt_i.scl_fall)
                        next_state = (ctl_ack && byte_idx != BIDX_W'(BYTES - 1))
                                     ? ST_TX : ST_IGNORE;
                ST_ARA_TX:
                    if (lost_arb)
                        next_state = ST_IGNORE;
                    else if (evt_i.scl_fall && last_bit)
                        next_state = ST_ARA_ACK;
                ST_ARA_ACK:
                    if (evt_i.scl_fall) next_state = ST_IGNORE;
                default: next_state = ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        unique case (state)
            ST_ADDR_ACK, ST_PTR_ACK: sda_oe_o = 1'b1;
            ST_TX, ST_ARA_TX:        sda_oe_o = ~tx_sh[7];
            default:                 sda_oe_o = 1'b0;
        endcase
    end

    // Datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            rx_sh    <= '0;
            tx_sh    <= '1;
            byte_idx <= '0;
            ptr      <= '0;
            rw_q     <= 1'b0;
            ara_q    <= 1'b0;
            ctl_ack  <= 1'b0;
        end else if (evt_i.start || evt_i.stop) begin
            bit_cnt <= '0;
            tx_sh   <= '1;
        end else begin
            unique case (state)
                ST_ADDR, ST_PTR: begin
                    if (evt_i.scl_rise) begin
                        rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s_i};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                    if (evt_i.scl_fall && bit_cnt == CNT_W'(BYTE_W)) begin
                        if (state == ST_ADDR) begin
                            rw_q  <= rx_sh[0];
                            ara_q <= ara_hit && !own_hit;
                        end else begin
                            ptr <= rx_sh[PTR_W-1:0];
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (evt_i.scl_fall) begin
                        bit_cnt  <= '0;
                        byte_idx <= '0;
                        if (ara_q)
                            tx_sh <= {DEV_ADDR_HI, strap_i, alert_i};
                        else if (rw_q)
                            tx_sh <= sel_word[REG_W-1 -: BYTE_W];
                    end
                end
                ST_TX, ST_ARA_TX: begin
                    if (evt_i.scl_fall) begin
                        tx_sh   <= {tx_sh[BYTE_W-2:0], 1'b1};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                ST_TX_ACK: begin
                    if (evt_i.scl_rise) ctl_ack <= !sda_s_i;
                    if (evt_i.scl_fall) begin
                        bit_cnt  <= '0;
                        tx_sh    <= next_byte;
                        byte_idx <= byte_idx + 1'b1;
                    end
                end
                default: begin
                    tx_sh <= '1;
                end
            endcase
        end
    end

    // Alert latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alert_in_q <= 1'b0;
            alert_o    <= 1'b0;
        end else begin
            alert_in_q <= alert_i;
            if (alert_i && !alert_in_q)
                alert_o <= 1'b1;
            else if (state == ST_ARA_TX && next_state == ST_ARA_ACK)
                alert_o <= 1'b0;
        end
    end

    // R11
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i.stop |=> !sda_oe_o);

    // R7
    restart_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i.start |=> (state == ST_ADDR && $stable(ptr)));

    // R6
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_PTR) |=> $stable(ptr));

    // R8
    ara_alert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARA_TX) |-> alert_o);

    // R10
    arb_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARA_TX && lost_arb) |=> (state == ST_IGNORE && alert_o && !sda_oe_o));

endmodule

// File: rtl/tws_sensor_target.sv
module tws_sensor_target
    import tws_pkg::*;
#(
    parameter int REG_W    = 16,
    parameter int NREG     = 4,
    parameter int FILT_LEN = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe_o,
    input  logic [1:0]            addr_strap_i,
    input  logic [NREG*REG_W-1:0] reg_data_i,
    input  logic                  alert_i,
    output logic                  alert_o
);
    logic [1:0] raw_lines;
    logic [1:0] clean_lines;
    bus_evt_t   evt;

    assign raw_lines = {scl_i, sda_i};

    for (genvar i = 0; i < 2; i++) begin : g_line
        tws_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw_i   (raw_lines[i]),
            .clean_o (clean_lines[i])
        );
    end

    tws_bus_events u_evt (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (clean_lines[1]),
        .sda_i (clean_lines[0]),
        .evt_o (evt)
    );

    tws_target_fsm #(.REG_W(REG_W), .NREG(NREG)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt),
        .sda_s_i  (clean_lines[0]),
        .strap_i  (addr_strap_i),
        .regs_i   (reg_data_i),
        .alert_i  (alert_i),
        .sda_oe_o (sda_oe_o),
        .alert_o  (alert_o)
    );

endmodule

// File: tb/tws_sensor_target_test.sv
module tws_sensor_target_test;
    localparam int H = 40;
    localparam int Q = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda_low = 1'b0;
    logic        sda_oe;
    logic        sda_bus;
    logic [1:0]  strap = 2'b01;
    logic [63:0] regs = {16'hC3A5, 16'h5A0F, 16'h8001, 16'h7E42};
    logic        alert_in = 1'b0;
    logic        alert_out;

    int n_chk = 0;
    int n_fail = 0;
    int mdl_ptr = 0;
    bit exp_alert = 1'b0;
    bit alert_dc = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    assign sda_bus = ~(m_sda_low | sda_oe);

    tws_sensor_target uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (m_scl),
        .sda_i        (sda_bus),
        .sda_oe_o     (sda_oe),
        .addr_strap_i (strap),
        .reg_data_i   (regs),
        .alert_i      (alert_in),
        .alert_o      (alert_out)
    );

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Per-clock comparison of the alert output with the reference model
    always begin
        @(posedge clk);
        #5;
        if (rst_n && !done && !alert_dc)
            chk(alert_out == exp_alert, "R8 alert_o", 16'(alert_out), 16'(exp_alert));
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda_low = 1'b0; wait_clk(H);
        m_scl = 1'b1;     wait_clk(H);
        m_sda_low = 1'b1; wait_clk(H);
        m_scl = 1'b0;     wait_clk(Q);
    endtask

    task automatic bus_stop();
        m_sda_low = 1'b1; wait_clk(H);
        m_scl = 1'b1;     wait_clk(H);
        m_sda_low = 1'b0; wait_clk(H);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            m_sda_low = ~b[i]; wait_clk(H);
            m_scl = 1'b1;      wait_clk(H / 2);
            if (glitch && i == 7) begin
                m_sda_low = 1'b1; wait_clk(1);
                m_sda_low = 1'b0; wait_clk(H / 2 - 1);
            end else begin
                wait_clk(H / 2);
            end
            m_scl = 1'b0; wait_clk(Q);
        end
        m_sda_low = 1'b0; wait_clk(H);
        m_scl = 1'b1;     wait_clk(H / 2);
        acked = !sda_bus;  wait_clk(H / 2);
        m_scl = 1'b0;     wait_clk(Q);
    endtask

    task automatic recv_byte(input bit ack, input logic [7:0] force_low, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            m_sda_low = force_low[i]; wait_clk(H);
            m_scl = 1'b1;             wait_clk(H / 2);
            b[i] = sda_bus;           wait_clk(H / 2);
            m_scl = 1'b0;             wait_clk(Q);
        end
        m_sda_low = ack; wait_clk(H);
        m_scl = 1'b1;    wait_clk(H);
        m_scl = 1'b0;    wait_clk(Q);
    endtask

    function automatic logic [7:0] own_addr(input bit rw);
        return {5'b10010, strap, rw};
    endfunction

    function automatic logic [15:0] mdl_word();
        return regs[mdl_ptr*16 +: 16];
    endfunction

    task automatic write_ptr(input int p);
        bit a;
        bus_start();
        send_byte(own_addr(1'b0), 1'b0, a);
        chk(a, "R2 addr write ack", 16'(a), 16'd1);
        send_byte(8'(p), 1'b0, a);
        chk(a, "R3 pointer ack", 16'(a), 16'd1);
        mdl_ptr = p;
        bus_stop();
    endtask

    task automatic read_reg(input int nbytes, input bit glitch, input string req);
        bit a;
        logic [7:0] b;
        logic [15:0] w;
        w = mdl_word();
        bus_start();
        send_byte(own_addr(1'b1), glitch, a);
        chk(a, {req, " addr read ack"}, 16'(a), 16'd1);
        recv_byte(nbytes > 1, 8'h00, b);
        chk(b == w[15:8], {req, " R4 high byte"}, 16'(b), 16'(w[15:8]));
        if (nbytes > 1) begin
            recv_byte(1'b0, 8'h00, b);
            chk(b == w[7:0], {req, " R4 low byte"}, 16'(b), 16'(w[7:0]));
        end else begin
            chk(sda_bus == 1'b1, "R5 released after NACK", 16'(sda_bus), 16'd1);
        end
        bus_stop();
        chk(sda_oe == 1'b0, "R11 released after STOP", 16'(sda_oe), 16'd0);
    endtask

    initial begin
        bit a;
        logic [7:0] b;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);

        // R1: reset state
        chk(sda_oe == 1'b0, "R1 sda released", 16'(sda_oe), 16'd0);
        chk(alert_out == 1'b0, "R1 alert low", 16'(alert_out), 16'd0);
        read_reg(2, 1'b0, "R1 pointer 0");

        // R3/R4: every register
        for (int k = 3; k >= 0; k--) begin
            write_ptr(k);
            read_reg(2, 1'b0, "R3 select");
        end

        // R6: pointer persists across STOP and reads
        write_ptr(2);
        read_reg(2, 1'b0, "R6 persist a");
        read_reg(2, 1'b0, "R6 persist b");

        // R5: single-byte read ends with NACK, next read works
        read_reg(1, 1'b0, "R5 single");
        read_reg(2, 1'b0, "R5 after single");

        // R2: wrong address ignored
        bus_start();
        send_byte({5'b10010, ~strap, 1'b1}, 1'b0, a);
        chk(!a, "R2 foreign addr nack", 16'(a), 16'd0);
        recv_byte(1'b0, 8'h00, b);
        chk(b == 8'hFF, "R2 silent after foreign addr", 16'(b), 16'hFF);
        bus_stop();

        // R2: strap change moves the address
        strap = 2'b10;
        wait_clk(10);
        read_reg(2, 1'b0, "R2 new strap");

        // R3: extra write bytes not acknowledged
        bus_start();
        send_byte(own_addr(1'b0), 1'b0, a);
        send_byte(8'h01, 1'b0, a);
        chk(a, "R3 pointer ack", 16'(a), 16'd1);
        mdl_ptr = 1;
        send_byte(8'hAA, 1'b0, a);
        chk(!a, "R3 extra byte nack", 16'(a), 16'd0);
        bus_stop();
        read_reg(2, 1'b0, "R3 pointer 1");

        // R7: repeated start after pointer, then after address only
        bus_start();
        send_byte(own_addr(1'b0), 1'b0, a);
        send_byte(8'h03, 1'b0, a);
        mdl_ptr = 3;
        bus_start();
        send_byte(own_addr(1'b1), 1'b0, a);
        chk(a, "R7 restart addr ack", 16'(a), 16'd1);
        recv_byte(1'b1, 8'h00, b);
        chk(b == 8'hC3, "R7 restart high", 16'(b), 16'hC3);
        recv_byte(1'b0, 8'h00, b);
        chk(b == 8'hA5, "R7 restart low", 16'(b), 16'hA5);
        bus_stop();
        bus_start();
        send_byte(own_addr(1'b0), 1'b0, a);
        bus_start();
        send_byte(own_addr(1'b1), 1'b0, a);
        recv_byte(1'b0, 8'h00, b);
        chk(b == 8'hC3, "R7 pointer unchanged", 16'(b), 16'hC3);
        bus_stop();

        // R11: short SDA glitch while SCL high is not a START/STOP
        read_reg(2, 1'b1, "R11 glitch");

        // R8: alert-response address not acked without alert
        bus_start();
        send_byte(8'h19, 1'b0, a);
        chk(!a, "R8 ARA nack w/o alert", 16'(a), 16'd0);
        bus_stop();

        // R8/R9: alert set, response wins, status 1, alert cleared
        alert_in = 1'b1; exp_alert = 1'b1;
        wait_clk(20);
        alert_dc = 1'b1;
        bus_start();
        send_byte(8'h19, 1'b0, a);
        chk(a, "R8 ARA ack", 16'(a), 16'd1);
        recv_byte(1'b0, 8'h00, b);
        chk(b == {5'b10010, strap, 1'b1}, "R9 ARA byte", 16'(b), 16'({5'b10010, strap, 1'b1}));
        bus_stop();
        exp_alert = 1'b0; alert_dc = 1'b0;
        chk(alert_out == 1'b0, "R9 alert cleared", 16'(alert_out), 16'd0);
        wait_clk(20);

        // R10: arbitration lost on the first bit
        alert_in = 1'b0; wait_clk(5);
        alert_in = 1'b1; exp_alert = 1'b1; wait_clk(5);
        alert_in = 1'b0; wait_clk(10);
        alert_dc = 1'b1;
        bus_start();
        send_byte(8'h19, 1'b0, a);
        chk(a, "R10 ARA ack", 16'(a), 16'd1);
        recv_byte(1'b0, 8'h80, b);
        chk(b == 8'h7F, "R10 released after loss", 16'(b), 16'h7F);
        bus_stop();
        alert_dc = 1'b0;
        chk(alert_out == 1'b1, "R10 alert kept", 16'(alert_out), 16'd1);

        // R9: second response wins with status 0
        alert_dc = 1'b1;
        bus_start();
        send_byte(8'h19, 1'b0, a);
        recv_byte(1'b0, 8'h00, b);
        chk(b == {5'b10010, strap, 1'b0}, "R9 ARA status 0", 16'(b), 16'({5'b10010, strap, 1'b0}));
        bus_stop();
        exp_alert = 1'b0; alert_dc = 1'b0;
        chk(alert_out == 1'b0, "R9 alert cleared again", 16'(alert_out), 16'd0);
        read_reg(2, 1'b0, "R6 after alert");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule